// File: doc/BRIEF.md
# Banked Scratchpad Pointer with Register File

This block holds a 6-bit indirect pointer into a 64-byte scratchpad and the scratchpad itself. The pointer is two octal digits. The upper digit selects one of eight banks of eight bytes. The lower digit selects a byte inside that bank. Stepping the pointer up or down changes only the lower digit and wraps it, so the pointer never leaves its bank. Each digit can also be loaded on its own from a 3-bit immediate.

The scratchpad is read combinationally at the current pointer. A write stores the data byte at the pointer value held before the clock edge. A read can therefore be combined with a step: the old location is returned, and the pointer moves on that same edge. The block also produces a loop-branch flag. The flag is high unless the lower digit equals 7. A sequencer uses it to step through a bank until the last byte.

The control inputs are plain per-cycle strobes with no handshake. Every request is taken in the cycle it is presented, so no back-pressure exists.

Top module: `sp_bank_ptr`

## Requirements
- R1: While reset is asserted, and on release, the pointer is 0 and every one of the 64 scratchpad bytes reads as 0.
- R2: An increment alone sets bits 2:0 to (old bits 2:0 + 1) mod 8, and bits 5:3 keep their value.
- R3: A decrement alone sets bits 2:0 to (old bits 2:0 − 1) mod 8, and bits 5:3 keep their value.
- R4: A load-upper alone writes the 3-bit immediate into bits 5:3, and bits 2:0 keep their value.
- R5: A load-lower alone writes the 3-bit immediate into bits 2:0, and bits 5:3 keep their value.
- R6: A load-upper and a load-lower in the same cycle write the immediate into both digits.
- R7: Any load overrides increment and decrement in that cycle, and increment overrides decrement. In each case the pointer takes the value that the winning operation alone would give.
- R8: The branch flag is 0 when bits 2:0 of the pointer equal 7 (binary 111), and 1 for every other value.
- R9: Read data always shows the byte at the current pointer. A write stores the write data at the pointer value present before the edge, even when the pointer moves on that same edge.
- R10: With no pointer operation requested, the pointer holds. A byte that is not written keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_up_i | input | 1 | Increment the lower digit within the bank |
| step_dn_i | input | 1 | Decrement the lower digit within the bank |
| load_hi_i | input | 1 | Load the upper digit from the immediate |
| load_lo_i | input | 1 | Load the lower digit from the immediate |
| imm_i | input | 3 | Immediate digit value |
| wr_en_i | input | 1 | Write the write data at the current pointer |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Byte at the current pointer |
| ptr_o | output | 6 | Current pointer |
| loop_ok_o | output | 1 | High unless the lower digit is 7 |

## Verification
Random cycles mix single operations, conflicting requests and writes that coincide with a step. This separates the priority order and shows whether a write lands on the old or the new address. Directed runs step up from 7 and down from 0 in a non-zero bank, which would expose a carry or borrow leaking into the upper digit. A walk over all 64 addresses after reset shows whether every byte was cleared. Loading 7 and then 6 into the lower digit shows whether the branch flag decodes the digit exactly.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [1:0] {
    PTR_HOLD = 2'd0,
    PTR_LOAD = 2'd1,
    PTR_UP   = 2'd2,
    PTR_DN   = 2'd3
  } ptr_op_e;
endpackage

// File: rtl/sp_op_sel.sv
module sp_op_sel
  import sp_pkg::*;
(
  input  logic    step_up,
  input  logic    step_dn,
  input  logic    load_hi,
  input  logic    load_lo,
  output ptr_op_e op
);
  // loads win, then up, then down
  always_comb begin
    if (load_hi || load_lo) op = PTR_LOAD;
    else if (step_up)       op = PTR_UP;
    else if (step_dn)       op = PTR_DN;
    else                    op = PTR_HOLD;
  end
endmodule

// File: rtl/sp_ptr_reg.sv
module sp_ptr_reg
  import sp_pkg::*;
#(
  parameter int DIGIT_W = 3,
  localparam int PTR_W = 2 * DIGIT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ptr_op_e            op,
  input  logic               load_hi,
  input  logic               load_lo,
  input  logic [DIGIT_W-1:0] imm,
  output logic [PTR_W-1:0]   ptr
);
  logic [DIGIT_W-1:0] hi_q, lo_q, hi_d, lo_d;

  always_comb begin
    hi_d = hi_q;
    lo_d = lo_q;
    unique case (op)
      PTR_LOAD: begin
        if (load_hi) hi_d = imm;
        if (load_lo) lo_d = imm;
      end
      PTR_UP:   lo_d = lo_q + DIGIT_W'(1);
      PTR_DN:   lo_d = lo_q - DIGIT_W'(1);
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign ptr = {hi_q, lo_q};
endmodule

// File: rtl/sp_regfile.sv
module sp_regfile #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    mem_q[g] <= '0;
      else if (wr_en && (addr == ADDR_W'(g)))        mem_q[g] <= wr_data;
    end
  end

  assign rd_data = mem_q[addr];
endmodule

// File: rtl/sp_loop_test.sv
module sp_loop_test #(
  parameter int DIGIT_W = 3
) (
  input  logic [DIGIT_W-1:0] lo_digit,
  output logic               loop_ok
);
  assign loop_ok = ~(&lo_digit);
endmodule

// File: rtl/sp_bank_ptr.sv
module sp_bank_ptr
  import sp_pkg::*;
#(
  parameter int DIGIT_W = 3,
  parameter int DATA_W  = 8,
  localparam int PTR_W  = 2 * DIGIT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step_up_i,
  input  logic               step_dn_i,
  input  logic               load_hi_i,
  input  logic               load_lo_i,
  input  logic [DIGIT_W-1:0] imm_i,
  input  logic               wr_en_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic [PTR_W-1:0]   ptr_o,
  output logic               loop_ok_o
);
  ptr_op_e op;

  sp_op_sel u_sel (
    .step_up (step_up_i),
    .step_dn (step_dn_i),
    .load_hi (load_hi_i),
    .load_lo (load_lo_i),
    .op      (op)
  );

  sp_ptr_reg #(.DIGIT_W(DIGIT_W)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .op      (op),
    .load_hi (load_hi_i),
    .load_lo (load_lo_i),
    .imm     (imm_i),
    .ptr     (ptr_o)
  );

  // write address is the pre-edge pointer, so a step in the same cycle does not move the write
  sp_regfile #(.ADDR_W(PTR_W), .DATA_W(DATA_W)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (ptr_o),
    .wr_en   (wr_en_i),
    .wr_data (wr_data_i),
    .rd_data (rd_data_o)
  );

  sp_loop_test #(.DIGIT_W(DIGIT_W)) u_loop (
    .lo_digit (ptr_o[DIGIT_W-1:0]),
    .loop_ok  (loop_ok_o)
  );
endmodule

// File: rtl/sp_bank_ptr_chk.sv
module sp_bank_ptr_chk #(
  parameter int DIGIT_W = 3,
  parameter int DATA_W  = 8,
  localparam int PTR_W  = 2 * DIGIT_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               step_up_i,
  input logic               step_dn_i,
  input logic               load_hi_i,
  input logic               load_lo_i,
  input logic [DIGIT_W-1:0] imm_i,
  input logic               wr_en_i,
  input logic [DATA_W-1:0]  wr_data_i,
  input logic [DATA_W-1:0]  rd_data_o,
  input logic [PTR_W-1:0]   ptr_o,
  input logic               loop_ok_o
);
  logic no_load;
  assign no_load = !load_hi_i && !load_lo_i;

  assert_step_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (no_load && step_up_i) |=>
      (ptr_o[PTR_W-1:DIGIT_W] == $past(ptr_o[PTR_W-1:DIGIT_W])) &&
      (ptr_o[DIGIT_W-1:0] == DIGIT_W'($past(ptr_o[DIGIT_W-1:0]) + DIGIT_W'(1))));

  assert_step_dn_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (no_load && !step_up_i && step_dn_i) |=>
      (ptr_o[PTR_W-1:DIGIT_W] == $past(ptr_o[PTR_W-1:DIGIT_W])) &&
      (ptr_o[DIGIT_W-1:0] == DIGIT_W'($past(ptr_o[DIGIT_W-1:0]) - DIGIT_W'(1))));

  assert_load_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_hi_i && !load_lo_i) |=>
      (ptr_o[PTR_W-1:DIGIT_W] == $past(imm_i)) &&
      (ptr_o[DIGIT_W-1:0] == $past(ptr_o[DIGIT_W-1:0])));

  assert_load_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_lo_i && !load_hi_i) |=>
      (ptr_o[DIGIT_W-1:0] == $past(imm_i)) &&
      (ptr_o[PTR_W-1:DIGIT_W] == $past(ptr_o[PTR_W-1:DIGIT_W])));

  assert_load_both_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_lo_i && load_hi_i) |=> (ptr_o == {$past(imm_i), $past(imm_i)}));

  assert_loop_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_lo_i && (&imm_i)) |=> !loop_ok_o);

  assert_wr_then_rd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && no_load && !step_up_i && !step_dn_i) |=> (rd_data_o == $past(wr_data_i)));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (no_load && !step_up_i && !step_dn_i) |=> $stable(ptr_o));
endmodule

bind sp_bank_ptr sp_bank_ptr_chk #(.DIGIT_W(DIGIT_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_sp_bank_ptr.sv
`timescale 1ns/1ps
module tb_sp_bank_ptr;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       step_up_i = 1'b0, step_dn_i = 1'b0, load_hi_i = 1'b0, load_lo_i = 1'b0;
  logic [2:0] imm_i = '0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rd_data_o;
  logic [5:0] ptr_o;
  logic       loop_ok_o;

  int errors = 0;
  int checks = 0;
  logic [5:0] m_ptr;
  logic [7:0] m_mem [64];
  string      ptr_tag;

  always #5 clk = ~clk;

  sp_bank_ptr dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] next_ptr(logic [5:0] p, bit up, bit dn, bit lh, bit ll, logic [2:0] im);
    logic [5:0] n = p;
    if (lh || ll) begin
      if (lh) n[5:3] = im;
      if (ll) n[2:0] = im;
    end else if (up) n[2:0] = p[2:0] + 3'd1;
    else if (dn)     n[2:0] = p[2:0] - 3'd1;
    return n;
  endfunction

  function automatic string op_tag(bit up, bit dn, bit lh, bit ll);
    if (lh && ll)                 return "R6";
    if ((lh || ll) && (up || dn)) return "R7";
    if (lh)                       return "R4";
    if (ll)                       return "R5";
    if (up && dn)                 return "R7";
    if (up)                       return "R2";
    if (dn)                       return "R3";
    return "R10";
  endfunction

  // inputs driven after negedge; outputs compared mid-low-phase; model updated at posedge
  task automatic cycle(bit up, bit dn, bit lh, bit ll, logic [2:0] im, bit we, logic [7:0] wd);
    step_up_i = up; step_dn_i = dn; load_hi_i = lh; load_lo_i = ll;
    imm_i = im; wr_en_i = we; wr_data_i = wd;
    #1;
    chk(ptr_o == m_ptr, ptr_tag, {2'b0, ptr_o}, {2'b0, m_ptr});
    chk(rd_data_o == m_mem[m_ptr], "R9", rd_data_o, m_mem[m_ptr]);
    chk(loop_ok_o == (m_ptr[2:0] != 3'd7), "R8", {7'b0, loop_ok_o}, {7'b0, m_ptr[2:0] != 3'd7});
    @(posedge clk);
    if (we) m_mem[m_ptr] = wd;
    m_ptr = next_ptr(m_ptr, up, dn, lh, ll, im);
    ptr_tag = op_tag(up, dn, lh, ll);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_ptr = '0;
    for (int i = 0; i < 64; i++) m_mem[i] = '0;
    ptr_tag = "R1";
    repeat (3) @(negedge clk);
    chk(ptr_o == 6'd0, "R1", {2'b0, ptr_o}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: walk every address after reset, expect all zero
    for (int h = 0; h < 8; h++) begin
      cycle(0, 0, 1, 1, 3'(h), 0, 8'h00);
      for (int l = 0; l < 7; l++) cycle(1, 0, 0, 0, 3'd0, 0, 8'h00);
    end
    // R2 wrap up from 7 in bank 5, R3 wrap down from 0
    cycle(0, 0, 1, 1, 3'd5, 0, 8'h00);
    cycle(0, 0, 0, 1, 3'd7, 0, 8'h00);
    cycle(1, 0, 0, 0, 3'd0, 0, 8'h00);
    cycle(1, 1, 0, 0, 3'd0, 0, 8'h00);
    cycle(0, 1, 0, 0, 3'd0, 0, 8'h00);
    cycle(0, 1, 0, 0, 3'd0, 0, 8'h00);
    // R8 boundary: lower digit 7 then 6
    cycle(0, 0, 0, 1, 3'd7, 0, 8'h00);
    cycle(0, 0, 0, 1, 3'd6, 0, 8'h00);
    // R9 write with step: lands on old address
    cycle(1, 0, 0, 0, 3'd0, 1, 8'hA5);
    cycle(0, 1, 0, 0, 3'd0, 0, 8'h00);
    // R7 load over step
    cycle(1, 1, 1, 0, 3'd2, 1, 8'h3C);
    cycle(0, 0, 0, 0, 3'd0, 0, 8'h00);
    // random mix
    for (int n = 0; n < 3000; n++) begin
      bit up = ($urandom % 3) == 0;
      bit dn = ($urandom % 3) == 0;
      bit lh = ($urandom % 6) == 0;
      bit ll = ($urandom % 6) == 0;
      bit we = ($urandom % 2) == 0;
      cycle(up, dn, lh, ll, 3'($urandom), we, 8'($urandom));
    end
    cycle(0, 0, 0, 0, 3'd0, 0, 8'h00);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule